// File: doc/BRIEF.md
# Many-Valued JK Grade Register

This block is a clocked register that stores a quantized fuzzy truth value, called a grade, instead of a single bit. On each rising clock edge it computes a new grade from the stored grade and two grade inputs, j_i and k_i. The calculation uses fuzzy AND (the minimum), fuzzy OR (the maximum) and fuzzy complement (full scale minus the value). A 2-bit mode input selects one of three next-state equations: reset-type, set-type or combined min-max. A fourth mode code keeps the stored grade unchanged.

A grade is an unsigned W-bit number from 0 to the full-scale value FULL. With the defaults, W is 3 and FULL is 6. Any input code above FULL is clamped to FULL before use. A load port writes a chosen starting grade, which lets a sequence of states be started from a known point. Some fixed input pairs make the stored grade oscillate from one clock to the next. The block reproduces that oscillation exactly and does not damp it. This makes the register usable for sequential many-valued logic and for studying the stability of fuzzy flip-flop equations.

Top module: `fz_jk_reg`

## Requirements
- R1: While rst_ni is low, q_o reads 0, and it stays 0 until the first clock edge that meets no reset.
- R2: If load_i is high at a rising edge, q_o takes the clamped load_val_i at that edge, whatever mode_i, j_i and k_i are.
- R3: An input code above FULL (6 by default) is treated as FULL, and q_o never exceeds FULL.
- R4: With mode_i = 0 (reset-type) and no load, the next q is max(min(J, FULL-Q), min(FULL-K, Q)).
- R5: With mode_i = 1 (set-type) and no load, the next q is min(max(J, Q), max(FULL-K, FULL-Q)).
- R6: With mode_i = 2 (combined) and no load, the next q is min(max(J, FULL-K), max(J, Q), max(FULL-K, FULL-Q)).
- R7: With mode_i = 3 and no load, q_o keeps its value.
- R8: In reset-type mode with J = K = 4 on the 0..6 scale, starting from Q = 0, q_o runs 4, 2, 4, 2 on successive clocks.
- R9: Under the same inputs, starting from Q = 2, q_o also runs 4, 2, 4, 2.
- R10: In reset-type mode starting from Q = 0, q_o changes on every clock for each of these input pairs: J=K=6 (6,0,6,0), J=4 K=6 (4,2,4,2) and J=6 K=4 (6,2,4,2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; q_o updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the stored grade to 0 |
| load_i | input | 1 | Writes load_val_i into the stored grade; takes priority over the JK update |
| load_val_i | input | W | Starting grade to load (clamped to FULL) |
| j_i | input | W | J grade (clamped to FULL) |
| k_i | input | W | K grade (clamped to FULL) |
| mode_i | input | 2 | Equation select: 0 reset-type, 1 set-type, 2 combined, 3 hold |
| q_o | output | W | Stored grade |

## Verification
On every cycle, the assertions check that the stored grade stays within full scale, that a load wins over the JK update, that hold mode leaves the grade unchanged, and that each equation's single-step result matches its min/max/complement formula for the inputs sampled at the previous edge. Only the bench's scenarios show the multi-cycle behaviour: the oscillation sequences that appear from given start grades, and the value held during an asynchronous reset. The bench also sweeps every mode, J, K and start-grade code, including the codes above full scale, and compares each step with an arithmetic model.

// File: rtl/fz_pkg.sv
package fz_pkg;
  typedef enum logic [1:0] {
    MODE_RST  = 2'd0,
    MODE_SET  = 2'd1,
    MODE_MIX  = 2'd2,
    MODE_HOLD = 2'd3
  } jk_mode_e;

  localparam int MODE_CNT = 3;
endpackage

// File: rtl/fz_clamp.sv
module fz_clamp #(
  parameter int W    = 3,
  parameter int FULL = 6
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sat_o
);
  localparam logic [W-1:0] FULL_V = W'(FULL);

  assign sat_o = (raw_i > FULL_V) ? FULL_V : raw_i;
endmodule

// File: rtl/fz_eq.sv
module fz_eq #(
  parameter int W    = 3,
  parameter int FULL = 6,
  parameter int KIND = 0
) (
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] FULL_V = W'(FULL);

  function automatic logic [W-1:0] f_and(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] f_or(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [W-1:0] nq, nk;
  assign nq = FULL_V - q_i;
  assign nk = FULL_V - k_i;

  generate
    if (KIND == 0) begin : g_rst
      assign nxt_o = f_or(f_and(j_i, nq), f_and(nk, q_i));
    end else if (KIND == 1) begin : g_set
      assign nxt_o = f_and(f_or(j_i, q_i), f_or(nk, nq));
    end else begin : g_mix
      assign nxt_o = f_and(f_and(f_or(j_i, nk), f_or(j_i, q_i)), f_or(nk, nq));
    end
  endgenerate
endmodule

// File: rtl/fz_next.sv
module fz_next
  import fz_pkg::*;
#(
  parameter int W    = 3,
  parameter int FULL = 6
) (
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] q_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cand [MODE_CNT];

  for (genvar g = 0; g < MODE_CNT; g++) begin : g_eq
    fz_eq #(.W(W), .FULL(FULL), .KIND(g)) u_eq (
      .j_i  (j_i),
      .k_i  (k_i),
      .q_i  (q_i),
      .nxt_o(cand[g])
    );
  end

  always_comb begin
    case (mode_i)
      MODE_RST: nxt_o = cand[0];
      MODE_SET: nxt_o = cand[1];
      MODE_MIX: nxt_o = cand[2];
      default:  nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/fz_jk_reg.sv
module fz_jk_reg #(
  parameter int W    = 3,
  parameter int FULL = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] j_s, k_s, ld_s, q_q, q_d;

  fz_clamp #(.W(W), .FULL(FULL)) u_cl_j  (.raw_i(j_i),        .sat_o(j_s));
  fz_clamp #(.W(W), .FULL(FULL)) u_cl_k  (.raw_i(k_i),        .sat_o(k_s));
  fz_clamp #(.W(W), .FULL(FULL)) u_cl_ld (.raw_i(load_val_i), .sat_o(ld_s));

  fz_next #(.W(W), .FULL(FULL)) u_next (
    .j_i   (j_s),
    .k_i   (k_s),
    .q_i   (q_q),
    .mode_i(mode_i),
    .nxt_o (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= ld_s;
    else             q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fz_jk_chk.sv
module fz_jk_chk #(
  parameter int W    = 3,
  parameter int FULL = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic [W-1:0] load_val_i,
  input logic [W-1:0] j_i,
  input logic [W-1:0] k_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] q_o
);
  function automatic int sat(input logic [W-1:0] x);
    return (int'(x) > FULL) ? FULL : int'(x);
  endfunction
  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (q_o == '0);
    end
  end

  // R3
  q_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_o) <= FULL);

  // R2
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> int'(q_o) == sat($past(load_val_i)));

  // R7
  hold_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mode_i == 2'd3) |=> $stable(q_o));

  // R4
  rst_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mode_i == 2'd0) |=> int'(q_o) ==
      mx(mn(sat($past(j_i)), FULL - int'($past(q_o))),
         mn(FULL - sat($past(k_i)), int'($past(q_o)))));

  // R5
  set_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mode_i == 2'd1) |=> int'(q_o) ==
      mn(mx(sat($past(j_i)), int'($past(q_o))),
         mx(FULL - sat($past(k_i)), FULL - int'($past(q_o)))));

  // R6
  mix_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mode_i == 2'd2) |=> int'(q_o) ==
      mn(mn(mx(sat($past(j_i)), FULL - sat($past(k_i))),
            mx(sat($past(j_i)), int'($past(q_o)))),
         mx(FULL - sat($past(k_i)), FULL - int'($past(q_o)))));
endmodule

bind fz_jk_reg fz_jk_chk #(.W(W), .FULL(FULL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .j_i       (j_i),
  .k_i       (k_i),
  .mode_i    (mode_i),
  .q_o       (q_o)
);

// File: tb/sim_fz_jk_reg.sv
`timescale 1ns/1ps
module sim_fz_jk_reg;
  localparam int W = 3;
  localparam int FULL = 6;

  logic clk = 0, rst_ni = 0, load_i = 0;
  logic [W-1:0] load_val_i = '0, j_i = '0, k_i = '0, q_o;
  logic [1:0] mode_i = '0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  fz_jk_reg #(.W(W), .FULL(FULL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .load_val_i(load_val_i),
    .j_i(j_i), .k_i(k_i), .mode_i(mode_i), .q_o(q_o)
  );

  function automatic int sat(input int x);
    return (x > FULL) ? FULL : x;
  endfunction
  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int model(input int m, input int j, input int k, input int q);
    int js, nk, nq;
    js = sat(j); nk = FULL - sat(k); nq = FULL - q;
    case (m)
      0: return mx(mn(js, nq), mn(nk, q));
      1: return mn(mx(js, q), mx(nk, nq));
      2: return mn(mn(mx(js, nk), mx(js, q)), mx(nk, nq));
      default: return q;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic osc(input string req, input int start, input int j, input int k,
                     input int e0, input int e1, input int e2, input int e3);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    mode_i = 2'd0; j_i = W'(j); k_i = W'(k);
    load_i = 1; load_val_i = W'(start); tick(); load_i = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(req, int'(q_o), exp[i]);
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: q_o=%0d expected finish", int'(q_o));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #12; check("R1", int'(q_o), 0);
    @(negedge clk); rst_ni = 1; #1;

    // R2..R7 exhaustive sweep incl. codes 7 above full scale (R3)
    for (int m = 0; m < 4; m++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          for (int q0 = 0; q0 < 8; q0++) begin
            mode_i = 2'(m); j_i = W'(j); k_i = W'(k);
            load_i = 1; load_val_i = W'(q0);
            tick();
            check("R2", int'(q_o), sat(q0));
            load_i = 0; load_val_i = W'(7 - q0);
            tick();
            case (m)
              0: check("R4", int'(q_o), model(0, j, k, sat(q0)));
              1: check("R5", int'(q_o), model(1, j, k, sat(q0)));
              2: check("R6", int'(q_o), model(2, j, k, sat(q0)));
              default: check("R7", int'(q_o), sat(q0));
            endcase
            if (int'(q_o) > FULL) check("R3", int'(q_o), FULL);
          end

    // oscillation sequences
    osc("R8", 0, 4, 4, 4, 2, 4, 2);
    osc("R9", 2, 4, 4, 4, 2, 4, 2);
    osc("R10", 0, 6, 6, 6, 0, 6, 0);
    osc("R10", 0, 4, 6, 4, 2, 4, 2);
    osc("R10", 0, 6, 4, 6, 2, 4, 2);

    // R1 asynchronous reset mid-run
    load_i = 1; load_val_i = 3'd5; tick(); load_i = 0; mode_i = 2'd3;
    @(negedge clk); rst_ni = 0; #1;
    check("R1", int'(q_o), 0);
    tick(); check("R1", int'(q_o), 0);
    @(negedge clk); rst_ni = 1;
    tick(); check("R7", int'(q_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule